// File: doc/BRIEF.md
# Keyed Countdown Watchdog

This block is a hardware watchdog built around a down-counter that steps once per prescaled tick of the system clock. With the default 17-bit prescaler, a 100 MHz clock gives a tick rate near 763 Hz. Software controls the watchdog through a single write strobe. Each write carries three fields: a new count, a command, and a 7-bit key.

A write takes effect only when its key is the bitwise complement of the key most recently accepted. Software therefore has to alternate between two complementary keys to keep the watchdog alive. A stray or runaway write that repeats the same key does nothing.

While the watchdog is running, the count falls by one on every tick. The block gives two warnings:
- When the count lands on one, it emits a single-cycle non-maskable interrupt request.
- When the count lands on zero, it raises a chip reset request. That request stays high until the block's own reset input is asserted.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the watchdog is stopped. `count_o` is 0, and `running_o`, `nmi_req` and `rst_req` are all low.
- R2: A write is accepted only when `wr_key` equals the bitwise inverse of the last accepted key. The last accepted key starts at 0 after reset, so the first accepted key is 7'h7F. Each accepted write stores its own key as the new reference.
- R3: A write whose key does not match is ignored entirely. The count, the run state and the key reference all stay unchanged, so the previously expected key is still the one accepted next.
- R4: An accepted write with `wr_cmd`=1 (start) loads `wr_count` into the counter and sets the run state. A start issued while the watchdog is already running behaves exactly like a first start.
- R5: An accepted start clears the prescaler. The counter then decreases by one every 2^DIV_W clock cycles, and the first decrement happens 2^DIV_W cycles after the load.
- R6: `nmi_req` is high for exactly one cycle: the first cycle in which `count_o` holds 1, whether the 1 came from a decrement or from a load.
- R7: `rst_req` goes high in the first cycle in which `count_o` holds 0 after a decrement or a load. It stays high until `rst_n` is asserted. From then on counting stops and every write is ignored.
- R8: An accepted write with `wr_cmd`=0 (stop) clears the run state and freezes the count. Its count field is ignored. A later accepted start resumes operation.
- R9: Loading a count of 0 raises `rst_req` in the very next cycle, and loading a count of 1 pulses `nmi_req` in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Control write strobe, one cycle per write |
| wr_cmd | input | 1 | Command of the write: 1 = start/reload, 0 = stop |
| wr_count | input | CNT_W | Count value loaded by a start |
| wr_key | input | KEY_W | Key of the write |
| count_o | output | CNT_W | Current counter value |
| running_o | output | 1 | Counter is counting |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| rst_req | output | 1 | Held chip reset request |

## Verification
The hardest state to reach is the moment a reload lands partway through a prescaler period. Checking it requires knowing that the old phase was discarded rather than carried over. The bench restarts the watchdog a few cycles after a start, then counts cycles until the first decrement. The bench also checks the count, the interrupt and the reset request on every cycle of a full run-down, for start values from 0 up to the counter maximum. These sweeps use a 3-bit prescaler so that a complete bite takes only a few thousand cycles. The key chain is followed across mismatched writes, and a following correct write proves that the key reference did not move.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  typedef enum logic {
    CMD_HALT = 1'b0,
    CMD_ARM  = 1'b1
  } kwd_cmd_e;
endpackage

// File: rtl/kwd_prescale.sv
module kwd_prescale #(
  parameter int DIV_W = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  logic [DIV_W-1:0] pre_q, pre_d;

  always_comb begin
    pre_d = pre_q;
    if (clr)      pre_d = '0;
    else if (run) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick = run && !clr && (&pre_q);

  // R5: a clear always drops the phase back to zero
  a_r5_clear_phase: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre_q == '0));
endmodule

// File: rtl/kwd_keygate.sv
module kwd_keygate #(
  parameter int KEY_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             lock,
  output logic             accept
);
  logic [KEY_W-1:0] key_q, key_d;

  assign accept = wr_en && !lock && (wr_key == ~key_q);

  always_comb begin
    key_d = key_q;
    if (accept) key_d = wr_key;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= '0;
    else        key_q <= key_d;
  end

  // R2: each accepted key is the complement of the one before it
  a_r2_key_flips: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (key_q == ~$past(key_q)));
  // R3: a rejected write leaves the reference alone
  a_r3_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !accept) |=> $stable(key_q));
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             halt,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             nmi,
  output logic             bite
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             run_d, nmi_d, bite_d, chg;

  always_comb begin
    cnt_d = cnt;
    run_d = running;
    chg   = 1'b0;
    if (load) begin
      cnt_d = ld_val;
      run_d = (ld_val != '0);
      chg   = 1'b1;
    end else if (halt) begin
      run_d = 1'b0;
    end else if (tick && running) begin
      cnt_d = cnt - 1'b1;
      chg   = 1'b1;
      if (cnt == ONE) run_d = 1'b0;
    end
    nmi_d  = chg && (cnt_d == ONE);
    bite_d = bite || (chg && (cnt_d == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      nmi     <= 1'b0;
      bite    <= 1'b0;
    end else begin
      cnt     <= cnt_d;
      running <= run_d;
      nmi     <= nmi_d;
      bite    <= bite_d;
    end
  end

  // R5: a tick while running steps the count down by exactly one
  a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && running && !load && !halt) |=> (cnt == $past(cnt) - 1'b1));
  // R8: a stop freezes the count
  a_r8_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !load) |=> ($stable(cnt) && !running));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int CNT_W = 8,
  parameter int KEY_W = 7,
  parameter int DIV_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_cmd,
  input  logic [CNT_W-1:0] wr_count,
  input  logic [KEY_W-1:0] wr_key,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             nmi_req,
  output logic             rst_req
);
  import kwd_pkg::*;

  logic [1:0] rsync_q;
  logic       rst_ni;
  logic       accept, load, halt, tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  kwd_keygate #(.KEY_W(KEY_W)) u_key (
    .clk    (clk),
    .rst_n  (rst_ni),
    .wr_en  (wr_en),
    .wr_key (wr_key),
    .lock   (rst_req),
    .accept (accept)
  );

  assign load = accept && (kwd_cmd_e'(wr_cmd) == CMD_ARM);
  assign halt = accept && (kwd_cmd_e'(wr_cmd) == CMD_HALT);

  kwd_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_ni),
    .clr   (load),
    .run   (running_o),
    .tick  (tick)
  );

  kwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_ni),
    .load    (load),
    .halt    (halt),
    .ld_val  (wr_count),
    .tick    (tick),
    .cnt     (count_o),
    .running (running_o),
    .nmi     (nmi_req),
    .bite    (rst_req)
  );

  // R6: interrupt request is a single-cycle pulse seen with a count of one
  a_r6_nmi_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    nmi_req |-> (count_o == CNT_W'(1)) ##1 !nmi_req);
  // R7: reset request holds once raised, and comes with a zero count
  a_r7_bite_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    rst_req |=> (rst_req && count_o == '0 && !running_o));
  // R4: a running watchdog never sits at zero
  a_r4_run_nonzero: assert property (@(posedge clk) disable iff (!rst_ni)
    running_o |-> (count_o != '0));
  // R1: nothing is requested right after reset release
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!rst_req && !nmi_req && !running_o));
endmodule

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb_top;
  localparam int CNT_W = 8;
  localparam int KEY_W = 7;
  localparam int DIV_W = 3;
  localparam int PER   = 1 << DIV_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_en, wr_cmd;
  logic [CNT_W-1:0] wr_count;
  logic [KEY_W-1:0] wr_key;
  logic [CNT_W-1:0] count_o;
  logic             running_o, nmi_req, rst_req;

  int n_run = 0;
  int n_bad = 0;
  logic [KEY_W-1:0] last_key;

  always #2.5 clk = ~clk;

  keyed_wdog #(.CNT_W(CNT_W), .KEY_W(KEY_W), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd),
    .wr_count(wr_count), .wr_key(wr_key), .count_o(count_o),
    .running_o(running_o), .nmi_req(nmi_req), .rst_req(rst_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    wr_en = 1'b0; wr_cmd = 1'b0; wr_count = '0; wr_key = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    last_key = '0;
  endtask

  // drive at a negedge, return at the negedge after the capturing edge
  task automatic wr(input logic cmd, input int cnt, input logic [KEY_W-1:0] key,
                    input bit good);
    wr_en = 1'b1; wr_cmd = cmd; wr_count = CNT_W'(cnt); wr_key = key;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    if (good) last_key = key;
  endtask

  function automatic logic [KEY_W-1:0] nxt();
    return ~last_key;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 count", int'(count_o), 0);
    chk("R1 running", int'(running_o), 0);
    chk("R1 nmi", int'(nmi_req), 0);
    chk("R1 rst_req", int'(rst_req), 0);

    // R5 R6 R7 R9: full run-down sweep, first key 7F (R2)
    for (int i = 0; i <= 8; i++) begin
      int n;
      n = (i == 8) ? 255 : i;
      do_reset();
      chk("R2 first key", int'(nxt()), 127);
      wr(1'b1, n, nxt(), 1'b1);
      for (int m = 0; m <= n * PER + 4; m++) begin
        int ec;
        ec = n - m / PER;
        if (ec < 0) ec = 0;
        chk("R5 count", int'(count_o), ec);
        chk("R6 nmi", int'(nmi_req), (n >= 1 && m == (n - 1) * PER) ? 1 : 0);
        chk("R7 rst_req", int'(rst_req), (m >= n * PER) ? 1 : 0);
        chk("R4 running", int'(running_o), (m < n * PER) ? 1 : 0);
        @(negedge clk);
      end
      // R7: writes after the bite are ignored
      wr(1'b1, 50, nxt(), 1'b0);
      chk("R7 ignore count", int'(count_o), 0);
      chk("R7 ignore rst_req", int'(rst_req), 1);
    end

    // R3: mismatched keys ignored, reference unchanged
    do_reset();
    wr(1'b1, 20, nxt(), 1'b1);
    wr(1'b1, 5, last_key, 1'b0);
    chk("R3 bad start count", int'(count_o), 20);
    wr(1'b0, 0, 7'h2A, 1'b0);
    chk("R3 bad stop running", int'(running_o), 1);
    wr(1'b1, 30, nxt(), 1'b1);
    chk("R3 good after bad", int'(count_o), 30);
    chk("R2 second key", int'(last_key), 0);

    // R4 R5: restart mid-period clears the prescaler
    repeat (5) @(negedge clk);
    wr(1'b1, 10, nxt(), 1'b1);
    for (int m = 0; m <= PER; m++) begin
      chk("R5 restart phase", int'(count_o), (m < PER) ? 10 : 9);
      @(negedge clk);
    end

    // R8: stop holds count and ignores its count field
    wr(1'b0, 99, nxt(), 1'b1);
    chk("R8 stopped", int'(running_o), 0);
    for (int m = 0; m < 5 * PER; m++) begin
      chk("R8 frozen", int'(count_o), 9);
      chk("R8 no nmi", int'(nmi_req), 0);
      @(negedge clk);
    end
    wr(1'b1, 3, nxt(), 1'b1);
    chk("R8 resume", int'(count_o), 3);
    chk("R8 resume running", int'(running_o), 1);

    // R2: key chain over several alternations
    for (int j = 0; j < 6; j++) begin
      wr(1'b1, 40 + j, nxt(), 1'b1);
      chk("R2 chain", int'(count_o), 40 + j);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule